// File: doc/BRIEF.md
# Bidirectional Cascadable Column Sampling Sequencer

This block produces the per-column sampling enables for a column driver with 240 outputs. The block captures a start pulse and passes it through a chain of stages. The chain runs in one of two directions. Every stage opens a sampling window for its own column, and that window lasts one full period of the shift clock. A digital track-and-hold cell for each column follows its assigned video input while the window is open. After the window closes, the cell keeps that value until the same column is sampled again. When power save is active, the column outputs are released.

The design runs from one system clock. The shift clock is presented as a strobe, `step_i`, with one strobe for each half-period of the shift clock. The chain therefore moves on both shift-clock edges without any dual-edge flops. The two cascade pins exchange roles with the direction input. One pin reads the start pulse and the other sends the pulse on to the next chip in a cascade. Each pin has its own output enable. The order input sets how the three video inputs are assigned to the repeating column pattern. The group input selects either one column per step or three adjacent columns per step.

Top module: `cascade_sampling_sequencer`

## Requirements
- R1: With `dir_i`=1, a start pulse on `cas_a_i` during a step enters column 0, and each later step moves the sampling position up by one column; `cas_b_i` is not a start source in this direction.
- R2: With `dir_i`=0, a start pulse on `cas_b_i` enters column 239, and each later step moves the position down by one column; `cas_a_i` is not a start source in this direction.
- R3: A column's window covers the step in which the pulse reaches it and the following step (one shift-clock period); while open, its 8-bit field (bits 8c+7..8c of `col_data_o`) follows its mapped video input every clock, and it is unchanged at all other times.
- R4: With `tri_mode_i`=1, the columns form groups 3g..3g+2 that are sampled together, the pulse moves one group per step, and it starts at group 0 going up or group 79 going down.
- R5: Column c uses phase c mod 3. With `order_i`=1, phases 0, 1 and 2 take video B, A and C. With `order_i`=0, they take C, B and A. The direction has no effect on this assignment.
- R6: `col_oe_o` follows `drive_en_i`: 1 drives the held values, 0 releases the column outputs; held values are kept either way.
- R7: The cascade output is high for exactly one step, starting at the step where the pulse leaves the last stage in the current direction (column 239 or group 79 going up, column 0 or group 0 going down). It appears on `cas_b_o` with `cas_b_oe_o`=1 when `dir_i`=1, and on `cas_a_o` with `cas_a_oe_o`=1 when `dir_i`=0. The non-driving pin's output and enable stay at 0.
- R8: A start pulse during a scan restarts the scan at the first stage, drops the partial scan, and suppresses any cascade pulse in that step.
- R9: On cycles without `step_i`, the sampling position and the cascade output do not change.
- R10: After reset, all held values are 0, no window is open, and both cascade outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | One-cycle strobe per shift-clock half period |
| dir_i | input | 1 | Chain direction: 1 up from column 0, 0 down from column 239 |
| tri_mode_i | input | 1 | 1 selects three-column simultaneous sampling |
| order_i | input | 1 | Video-to-column assignment order |
| drive_en_i | input | 1 | 1 drives column outputs, 0 releases them |
| vid_a_i | input | 8 | Video input A |
| vid_b_i | input | 8 | Video input B |
| vid_c_i | input | 8 | Video input C |
| cas_a_i | input | 1 | Cascade pin A, input side |
| cas_b_i | input | 1 | Cascade pin B, input side |
| cas_a_o | output | 1 | Cascade pin A, output side |
| cas_a_oe_o | output | 1 | Cascade pin A output enable |
| cas_b_o | output | 1 | Cascade pin B, output side |
| cas_b_oe_o | output | 1 | Cascade pin B output enable |
| col_data_o | output | 1920 | Held value of every column, column c at bits 8c+7..8c |
| col_oe_o | output | 1 | Output enable for all columns |

## Verification
The hardest state to reach is a restart that lands on the exact step in which the pulse would leave the last stage. At that step a cascade pulse would normally start, and the restart must suppress it, so the timing has to match to the step. The bench counts steps from the start pulse and issues the second start pulse on precisely that step. This is done once going up in three-column mode and once going down in single-column mode. The video inputs change every clock, so a window that is one step too short or too long leaves a visibly different held value in the affected column.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [1:0] {
    SRC_A = 2'd0,
    SRC_B = 2'd1,
    SRC_C = 2'd2
  } vid_src_e;

  localparam int unsigned GROUP_SIZE = 3;

  // Assignment of the three video inputs to the three column phases.
  function automatic vid_src_e pick_src(input int unsigned phase, input logic order);
    vid_src_e s;
    case (phase)
      0:       s = order ? SRC_B : SRC_C;
      1:       s = order ? SRC_A : SRC_B;
      default: s = order ? SRC_C : SRC_A;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sseq_reset_sync.sv
module sseq_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sseq_chain.sv
module sseq_chain #(
  parameter int unsigned NUM_COLS = 240
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                start_i,
  input  logic                dir_i,
  input  logic                tri_i,
  output logic [NUM_COLS-1:0] col_en_o,
  output logic [NUM_COLS-1:0] tok_o,
  output logic                casc_o
);
  import sseq_pkg::*;
  localparam int unsigned G = GROUP_SIZE;

  logic [NUM_COLS-1:0] tok_q, tok_d, prev_q, prev_d;
  logic [NUM_COLS-1:0] first_v, shift_v, win_v;
  logic                casc_q, casc_d, last_b;

  always_comb begin
    first_v = '0;
    if (dir_i)      first_v[0]          = 1'b1;
    else if (tri_i) first_v[NUM_COLS-G] = 1'b1;
    else            first_v[NUM_COLS-1] = 1'b1;

    if (dir_i) shift_v = tri_i ? (tok_q << G) : (tok_q << 1);
    else       shift_v = tri_i ? (tok_q >> G) : (tok_q >> 1);

    if (dir_i) last_b = tri_i ? tok_q[NUM_COLS-G] : tok_q[NUM_COLS-1];
    else       last_b = tok_q[0];

    tok_d  = tok_q;
    prev_d = prev_q;
    casc_d = casc_q;
    if (step_i) begin
      if (start_i) begin
        tok_d  = first_v;
        prev_d = '0;
        casc_d = 1'b0;
      end else begin
        tok_d  = shift_v;
        prev_d = tok_q;
        casc_d = last_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q  <= '0;
      prev_q <= '0;
      casc_q <= 1'b0;
    end else begin
      tok_q  <= tok_d;
      prev_q <= prev_d;
      casc_q <= casc_d;
    end
  end

  // A window covers the current and the previous pulse position.
  assign win_v = tok_q | prev_q;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_en
    localparam int unsigned BASE = c - (c % G);
    assign col_en_o[c] = tri_i ? win_v[BASE] : win_v[c];
  end

  assign tok_o  = tok_q;
  assign casc_o = casc_q;
endmodule

// File: rtl/sseq_col_cell.sv
module sseq_col_cell #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PHASE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              order_i,
  input  logic [DATA_W-1:0] vid_a_i,
  input  logic [DATA_W-1:0] vid_b_i,
  input  logic [DATA_W-1:0] vid_c_i,
  output logic [DATA_W-1:0] hold_o
);
  import sseq_pkg::*;

  logic [DATA_W-1:0] hold_q, hold_d, pick;
  vid_src_e          src;

  always_comb begin
    src = pick_src(PHASE, order_i);
    case (src)
      SRC_A:   pick = vid_a_i;
      SRC_B:   pick = vid_b_i;
      default: pick = vid_c_i;
    endcase
    hold_d = en_i ? pick : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/cascade_sampling_sequencer.sv
module cascade_sampling_sequencer #(
  parameter int unsigned NUM_COLS = 240,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step_i,
  input  logic                       dir_i,
  input  logic                       tri_mode_i,
  input  logic                       order_i,
  input  logic                       drive_en_i,
  input  logic [DATA_W-1:0]          vid_a_i,
  input  logic [DATA_W-1:0]          vid_b_i,
  input  logic [DATA_W-1:0]          vid_c_i,
  input  logic                       cas_a_i,
  input  logic                       cas_b_i,
  output logic                       cas_a_o,
  output logic                       cas_a_oe_o,
  output logic                       cas_b_o,
  output logic                       cas_b_oe_o,
  output logic [NUM_COLS*DATA_W-1:0] col_data_o,
  output logic                       col_oe_o
);
  import sseq_pkg::*;

  logic                rst_sync_n;
  logic                start_w;
  logic                casc_w;
  logic [NUM_COLS-1:0] col_en_w;
  logic [NUM_COLS-1:0] tok_w;

  sseq_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Direction picks which cascade pin is the start input.
  assign start_w = dir_i ? cas_a_i : cas_b_i;

  sseq_chain #(.NUM_COLS(NUM_COLS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step_i   (step_i),
    .start_i  (start_w),
    .dir_i    (dir_i),
    .tri_i    (tri_mode_i),
    .col_en_o (col_en_w),
    .tok_o    (tok_w),
    .casc_o   (casc_w)
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    sseq_col_cell #(.DATA_W(DATA_W), .PHASE(c % GROUP_SIZE)) u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .en_i    (col_en_w[c]),
      .order_i (order_i),
      .vid_a_i (vid_a_i),
      .vid_b_i (vid_b_i),
      .vid_c_i (vid_c_i),
      .hold_o  (col_data_o[c*DATA_W +: DATA_W])
    );
  end

  assign cas_a_oe_o = ~dir_i;
  assign cas_b_oe_o = dir_i;
  assign cas_a_o    = casc_w & ~dir_i;
  assign cas_b_o    = casc_w & dir_i;
  assign col_oe_o   = drive_en_i;
endmodule

// File: rtl/sseq_checker.sv
module sseq_checker #(
  parameter int unsigned NUM_COLS = 240,
  parameter int unsigned DATA_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_i,
  input logic                start_i,
  input logic                dir_i,
  input logic                tri_i,
  input logic [NUM_COLS-1:0] tok,
  input logic                en0,
  input logic [DATA_W-1:0]   col0,
  input logic                cas_a_o,
  input logic                cas_a_oe,
  input logic                cas_b_o,
  input logic                cas_b_oe
);
  a_r1_start_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && start_i && dir_i) |=> tok[0]);

  a_r2_start_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && start_i && !dir_i && !tri_i) |=> tok[NUM_COLS-1]);

  a_r3_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !en0 |=> $stable(col0));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tok) <= 1);

  a_r9_no_step_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(tok));

  a_r7_a_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cas_a_o |-> cas_a_oe);

  a_r7_b_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cas_b_o |-> cas_b_oe);
endmodule

bind cascade_sampling_sequencer sseq_checker #(.NUM_COLS(NUM_COLS), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .step_i   (step_i),
  .start_i  (start_w),
  .dir_i    (dir_i),
  .tri_i    (tri_mode_i),
  .tok      (tok_w),
  .en0      (col_en_w[0]),
  .col0     (col_data_o[DATA_W-1:0]),
  .cas_a_o  (cas_a_o),
  .cas_a_oe (cas_a_oe_o),
  .cas_b_o  (cas_b_o),
  .cas_b_oe (cas_b_oe_o)
);

// File: tb/cascade_sampling_sequencer_tb_top.sv
module cascade_sampling_sequencer_tb_top;
  localparam int N = 240;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic step_i, dir_i, tri_mode_i, order_i, drive_en_i;
  logic [W-1:0] vid_a_i, vid_b_i, vid_c_i;
  logic cas_a_i, cas_b_i;
  logic cas_a_o, cas_a_oe_o, cas_b_o, cas_b_oe_o;
  logic [N*W-1:0] col_data_o;
  logic col_oe_o;

  always #4 clk = ~clk;

  cascade_sampling_sequencer #(.NUM_COLS(N), .DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
    .tri_mode_i(tri_mode_i), .order_i(order_i), .drive_en_i(drive_en_i),
    .vid_a_i(vid_a_i), .vid_b_i(vid_b_i), .vid_c_i(vid_c_i),
    .cas_a_i(cas_a_i), .cas_b_i(cas_b_i),
    .cas_a_o(cas_a_o), .cas_a_oe_o(cas_a_oe_o),
    .cas_b_o(cas_b_o), .cas_b_oe_o(cas_b_oe_o),
    .col_data_o(col_data_o), .col_oe_o(col_oe_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R10";
  bit done = 0;

  // Behavioural reference model
  int m_pos = -1;
  int m_prev = -1;
  bit m_casc = 0;
  logic [W-1:0] m_hold [N];

  function automatic logic [W-1:0] model_pick(int c);
    int ph = c % 3;
    if (order_i) return (ph == 0) ? vid_b_i : (ph == 1) ? vid_a_i : vid_c_i;
    else         return (ph == 0) ? vid_c_i : (ph == 1) ? vid_b_i : vid_a_i;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = -1; m_prev = -1; m_casc = 0;
      for (int c = 0; c < N; c++) m_hold[c] = '0;
    end else begin
      int stride;
      stride = tri_mode_i ? 3 : 1;
      for (int c = 0; c < N; c++) begin
        int base;
        base = tri_mode_i ? c - (c % 3) : c;
        if (base == m_pos || base == m_prev) m_hold[c] = model_pick(c);
      end
      if (step_i) begin
        if (dir_i ? cas_a_i : cas_b_i) begin
          m_casc = 0; m_prev = -1;
          m_pos = dir_i ? 0 : N - stride;
        end else begin
          int np;
          m_casc = (m_pos >= 0) && (dir_i ? (m_pos == N - stride) : (m_pos == 0));
          m_prev = m_pos;
          if (m_pos < 0) np = -1;
          else begin
            np = dir_i ? m_pos + stride : m_pos - stride;
            if (np < 0 || np > N - 1) np = -1;
          end
          m_pos = np;
        end
      end
    end
  end

  task automatic check_bits(string req, string what, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  task automatic check_data(string req);
    int bad_c = -1;
    n_cmp++;
    for (int c = 0; c < N; c++)
      if (bad_c < 0 && col_data_o[c*W +: W] !== m_hold[c]) bad_c = c;
    if (bad_c >= 0) begin
      n_bad++;
      $display("FAIL %s column %0d at cycle %0d: actual %h expected %h",
               req, bad_c, cyc, col_data_o[bad_c*W +: W], m_hold[bad_c]);
    end
  endtask

  // Per-clock comparison (R3 R5 data, R7 cascade pins, R6 enable)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check_data(cur_req);
      check_bits(cur_req, "cascade pins", {cas_a_o, cas_a_oe_o, cas_b_o, cas_b_oe_o},
                 {m_casc & ~dir_i, ~dir_i, m_casc & dir_i, dir_i});
      check_bits("R6", "col_oe", {3'b0, col_oe_o}, {3'b0, drive_en_i});
    end
  end

  task automatic tick(input logic st, input logic pa, input logic pb);
    @(posedge clk); #3;
    cyc++;
    step_i  = st;
    cas_a_i = pa;
    cas_b_i = pb;
    vid_a_i = W'(cyc * 7 + 1);
    vid_b_i = W'(cyc * 13 + 5);
    vid_c_i = W'(cyc * 29 + 11);
  endtask

  task automatic start_scan();
    tick(1'b1, dir_i, ~dir_i);
    tick(1'b0, 1'b0, 1'b0);
  endtask

  task automatic run_steps(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick(1'b1, 1'b0, 1'b0);
      for (int g = 0; g < gap; g++) tick(1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    rst_n = 0; step_i = 0; dir_i = 1; tri_mode_i = 0; order_i = 1; drive_en_i = 1;
    vid_a_i = '0; vid_b_i = '0; vid_c_i = '0; cas_a_i = 0; cas_b_i = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    repeat (2) @(negedge clk);
    // R10: reset state
    cur_req = "R10";
    check_bits("R10", "cascade after reset", {cas_a_o, cas_b_o, 2'b0}, 4'b0);
    check_bits("R10", "col0 after reset", col_data_o[3:0], 4'b0);
    repeat (4) tick(1'b0, 1'b0, 1'b0);

    // R1 + R3 + R5 (order B,A,C) + R9 (idle gaps)
    cur_req = "R1"; dir_i = 1; tri_mode_i = 0; order_i = 1;
    tick(1'b1, 1'b0, 1'b1);           // wrong pin: ignored (R1)
    tick(1'b0, 1'b0, 1'b0);
    start_scan();
    run_steps(244, 1);
    cur_req = "R9";
    run_steps(4, 3);

    // R2 + R5 (order C,B,A), R6 power save mid-scan
    cur_req = "R2"; dir_i = 0; order_i = 0;
    tick(1'b1, 1'b1, 1'b0);           // wrong pin: ignored (R2)
    tick(1'b0, 1'b0, 1'b0);
    start_scan();
    run_steps(60, 1);
    cur_req = "R6"; drive_en_i = 0;
    run_steps(30, 1);
    drive_en_i = 1;
    cur_req = "R2";
    run_steps(154, 0);

    // R4 three-column mode, both directions
    cur_req = "R4"; dir_i = 1; tri_mode_i = 1; order_i = 1;
    start_scan();
    run_steps(84, 1);
    dir_i = 0; order_i = 0;
    start_scan();
    run_steps(84, 2);

    // R7 cascade timing in both directions, single mode
    cur_req = "R7"; tri_mode_i = 0; dir_i = 1;
    start_scan();
    run_steps(243, 0);
    dir_i = 0;
    start_scan();
    run_steps(243, 0);

    // R8 restart mid-scan, then restart exactly on the leaving step
    cur_req = "R8"; dir_i = 1; tri_mode_i = 0; order_i = 1;
    start_scan();
    run_steps(50, 1);
    start_scan();
    run_steps(243, 1);
    tri_mode_i = 1;
    start_scan();
    run_steps(79, 1);                 // pulse at group 79
    start_scan();                     // restart on the leaving step
    run_steps(82, 1);
    tri_mode_i = 0; dir_i = 0;
    start_scan();
    run_steps(239, 1);                // pulse at column 0
    start_scan();
    run_steps(243, 1);

    repeat (3) tick(1'b0, 1'b0, 1'b0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule